// File: doc/BRIEF.md
# Paged 32-bit Register Read-Modify-Write Sequencer

This block changes a 32-bit register that sits behind a 16-bit management bus. A host hands it one command made of a 32-bit register address, a clear mask and a set mask. The block then drives a transaction port that carries single 16-bit management reads and writes, one at a time. It runs a fixed sequence of five transactions: it selects the page, reads the two halves of the register, merges them with the masks, and writes the two halves back.

The register address is split into four fields. Bits 4:0 give the register number, bits 7:5 a 3-bit device sub-address, bits 23:8 a 16-bit page, and bits 31:24 an 8-bit switch address. The page-select write goes to a device address built from a high prefix (0x18) and the upper bits of the switch address. The data accesses go to a device address built from a low prefix (0x10) and the sub-address. The upper half of the register is reached by setting bit 1 of the register number.

When the sequence finishes or fails, the block pulses done once. With that pulse it returns an error flag and a 32-bit value. The serial frame generation and bus arbitration are handled outside the block, behind the transaction port.

Top module: `mdio32_rmw_seq`

## Requirements
- R1: After reset, cmd_ready is 1, txn_req is 0 and done is 0.
- R2: The first transaction after a command is accepted is a write (txn_write=1). Its txn_phy is 0x18 OR (addr[31:24] >> 5), its txn_reg is addr[28:24], and its txn_wdata is addr[23:8].
- R3: The second and third transactions are reads (txn_write=0) with txn_phy = 0x10 OR addr[7:5]. The second uses txn_reg = addr[4:0] and supplies the low half. The third uses txn_reg = addr[4:0] OR 0x02 and supplies the high half.
- R4: The fourth and fifth transactions are writes with txn_phy = 0x10 OR addr[7:5]. The fourth writes the low half of the merged value to txn_reg = addr[4:0]. The fifth writes the high half to txn_reg = addr[4:0] OR 0x02.
- R5: The merged value is ({high, low} AND NOT clear) OR set.
- R6: A request stays raised with stable txn_phy, txn_reg and txn_wdata until a response (rsp_valid) arrives. After that response, txn_req is low for at least one cycle before the next request.
- R7: cmd_ready is low from the cycle after acceptance until done. A cmd_valid that arrives in that interval is ignored and does not change the sequence.
- R8: A response with rsp_err=1 ends the sequence. The next cycle has done=1 and done_err=1, and no further transaction is issued. done_data then holds the halves read successfully so far, with any half not yet read shown as 0.
- R9: done is a one-cycle pulse, and cmd_ready is 1 in the next cycle. On success, done_err=0 and done_data is the merged value.
- R10: A successful command produces exactly five transactions and an aborted one produces none after the failing one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted when cmd_valid is also 1 |
| cmd_addr | input | 32 | Packed register address |
| cmd_clr | input | 32 | Bits to clear |
| cmd_set | input | 32 | Bits to set |
| txn_req | output | 1 | Transaction request raised |
| txn_write | output | 1 | 1 = write, 0 = read |
| txn_phy | output | 5 | Device address of the transaction |
| txn_reg | output | 5 | Register number of the transaction |
| txn_wdata | output | 16 | Write data |
| rsp_valid | input | 1 | Transaction response, sampled while txn_req is 1 |
| rsp_err | input | 1 | Transaction failed |
| rsp_rdata | input | 16 | Read data of the response |
| done | output | 1 | Sequence finished (one cycle) |
| done_err | output | 1 | Sequence aborted on an error |
| done_data | output | 32 | Merged value, or the partial read value on error |

## Verification
The bench builds the block with its default parameters: a 32-bit register, 16-bit halves, prefixes 0x18 and 0x10, and bit 1 as the selector for the upper half. With these values the field arithmetic can be checked against addresses at both extremes, all zeros and a switch address whose upper bits set the page prefix fully.

The bench's bus model answers after 0 to 3 cycles. This exercises the hold and gap rules of the request. It also injects an error at each of the five steps, which covers every partial-read value reported on abort.

// File: rtl/mdio32_pkg.sv
package mdio32_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PAGE  = 3'd1,
    ST_RD_LO = 3'd2,
    ST_RD_HI = 3'd3,
    ST_WR_LO = 3'd4,
    ST_WR_HI = 3'd5,
    ST_DONE  = 3'd6
  } seq_state_e;

endpackage

// File: rtl/mdio32_addr_map.sv
module mdio32_addr_map #(
  parameter int REG_W     = 32,
  parameter int PHY_AW    = 5,
  parameter int REGNUM_W  = 5,
  parameter int SUB_W     = 3,
  parameter int PAGE_W    = 16,
  parameter int UPPER_BIT = 1,
  parameter logic [PHY_AW-1:0] PAGE_PREFIX = 5'h18,
  parameter logic [PHY_AW-1:0] DATA_PREFIX = 5'h10
) (
  input  logic [REG_W-1:0]    addr,
  output logic [PHY_AW-1:0]   page_phy,
  output logic [REGNUM_W-1:0] page_reg,
  output logic [PAGE_W-1:0]   page_val,
  output logic [PHY_AW-1:0]   data_phy,
  output logic [REGNUM_W-1:0] reg_lo,
  output logic [REGNUM_W-1:0] reg_hi
);
  localparam int SUB_LSB  = REGNUM_W;
  localparam int PAGE_LSB = REGNUM_W + SUB_W;
  localparam int SW_LSB   = PAGE_LSB + PAGE_W;
  localparam int SW_W     = REG_W - SW_LSB;

  logic [SW_W-1:0]  sw_field;
  logic [SUB_W-1:0] sub_field;

  always_comb begin
    sw_field  = addr[REG_W-1:SW_LSB];
    sub_field = addr[PAGE_LSB-1:SUB_LSB];
    page_val  = addr[SW_LSB-1:PAGE_LSB];
    reg_lo    = addr[REGNUM_W-1:0];
    reg_hi    = addr[REGNUM_W-1:0] | (REGNUM_W'(1) << UPPER_BIT);
    page_reg  = sw_field[REGNUM_W-1:0];
    page_phy  = PAGE_PREFIX | PHY_AW'(sw_field >> REGNUM_W);
    data_phy  = DATA_PREFIX | PHY_AW'(sub_field);
  end

endmodule

// File: rtl/mdio32_merge.sv
module mdio32_merge #(
  parameter int REG_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [REG_W-1:0]     clr_in,
  input  logic [REG_W-1:0]     set_in,
  input  logic                 cap_lo,
  input  logic                 cap_hi,
  input  logic [REG_W/2-1:0]   rdata,
  output logic [REG_W-1:0]     raw_val,
  output logic [REG_W-1:0]     merged_val
);
  localparam int HALF_W = REG_W / 2;

  logic [REG_W-1:0]  clr_q, set_q;
  logic [HALF_W-1:0] lo_q, hi_q;
  logic [HALF_W-1:0] lo_d, hi_d;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (load) begin
      lo_d = '0;
      hi_d = '0;
    end else begin
      if (cap_lo) lo_d = rdata;
      if (cap_hi) hi_d = rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= '0;
      set_q <= '0;
    end else if (load) begin
      clr_q <= clr_in;
      set_q <= set_in;
    end
  end

  always_comb begin
    raw_val    = {hi_q, lo_q};
    merged_val = (raw_val & ~clr_q) | set_q;
  end

  // R3: a half is never captured while a new command loads
  always_ff @(posedge clk) begin
    if (rst_n) AST_NO_CAP_ON_LOAD: assert (!(load && (cap_lo || cap_hi))); // R3
  end

endmodule

// File: rtl/mdio32_seq_fsm.sv
module mdio32_seq_fsm
  import mdio32_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rsp_valid,
  input  logic       rsp_err,
  output seq_state_e state,
  output logic       txn_req,
  output logic       cap_lo,
  output logic       cap_hi,
  output logic       idle,
  output logic       done,
  output logic       done_err
);
  seq_state_e state_q, state_d;
  logic gap_q, gap_d;
  logic err_q, err_d;
  logic in_txn, take_rsp;

  always_comb begin
    in_txn   = (state_q == ST_PAGE) || (state_q == ST_RD_LO) || (state_q == ST_RD_HI) ||
               (state_q == ST_WR_LO) || (state_q == ST_WR_HI);
    txn_req  = in_txn && !gap_q;
    take_rsp = txn_req && rsp_valid;
    cap_lo   = take_rsp && !rsp_err && (state_q == ST_RD_LO);
    cap_hi   = take_rsp && !rsp_err && (state_q == ST_RD_HI);
    idle     = (state_q == ST_IDLE);
    done     = (state_q == ST_DONE);
    done_err = err_q;
    state    = state_q;
  end

  always_comb begin
    state_d = state_q;
    gap_d   = take_rsp;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_PAGE;
        err_d   = 1'b0;
      end
      ST_DONE: state_d = ST_IDLE;
      default: if (take_rsp) begin
        if (rsp_err) begin
          state_d = ST_DONE;
          err_d   = 1'b1;
        end else begin
          unique case (state_q)
            ST_PAGE:  state_d = ST_RD_LO;
            ST_RD_LO: state_d = ST_RD_HI;
            ST_RD_HI: state_d = ST_WR_LO;
            ST_WR_LO: state_d = ST_WR_HI;
            default:  state_d = ST_DONE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gap_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      gap_q   <= gap_d;
      err_q   <= err_d;
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && !rsp_valid) |=> txn_req); // R6
  AST_GAP_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && rsp_valid) |=> !txn_req); // R6
  AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && rsp_valid && rsp_err) |=> (done && done_err && !txn_req)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && idle)); // R9

endmodule

// File: rtl/mdio32_rmw_seq.sv
module mdio32_rmw_seq
  import mdio32_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int PHY_AW    = 5,
  parameter int REGNUM_W  = 5,
  parameter int SUB_W     = 3,
  parameter int UPPER_BIT = 1,
  parameter logic [PHY_AW-1:0] PAGE_PREFIX = 5'h18,
  parameter logic [PHY_AW-1:0] DATA_PREFIX = 5'h10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [REG_W-1:0]     cmd_addr,
  input  logic [REG_W-1:0]     cmd_clr,
  input  logic [REG_W-1:0]     cmd_set,
  output logic                 txn_req,
  output logic                 txn_write,
  output logic [PHY_AW-1:0]    txn_phy,
  output logic [REGNUM_W-1:0]  txn_reg,
  output logic [REG_W/2-1:0]   txn_wdata,
  input  logic                 rsp_valid,
  input  logic                 rsp_err,
  input  logic [REG_W/2-1:0]   rsp_rdata,
  output logic                 done,
  output logic                 done_err,
  output logic [REG_W-1:0]     done_data
);
  localparam int HALF_W = REG_W / 2;

  seq_state_e state;
  logic accept, cap_lo, cap_hi, idle;
  logic [REG_W-1:0]    addr_q;
  logic [REG_W-1:0]    raw_val, merged_val;
  logic [PHY_AW-1:0]   page_phy, data_phy;
  logic [REGNUM_W-1:0] page_reg, reg_lo, reg_hi;
  logic [HALF_W-1:0]   page_val;

  assign cmd_ready = idle;
  assign accept    = cmd_valid && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (accept) addr_q <= cmd_addr;
  end

  mdio32_seq_fsm u_fsm (
    .clk, .rst_n,
    .start     (accept),
    .rsp_valid,
    .rsp_err,
    .state,
    .txn_req,
    .cap_lo,
    .cap_hi,
    .idle,
    .done,
    .done_err
  );

  mdio32_addr_map #(
    .REG_W(REG_W), .PHY_AW(PHY_AW), .REGNUM_W(REGNUM_W), .SUB_W(SUB_W),
    .PAGE_W(HALF_W), .UPPER_BIT(UPPER_BIT),
    .PAGE_PREFIX(PAGE_PREFIX), .DATA_PREFIX(DATA_PREFIX)
  ) u_map (
    .addr     (addr_q),
    .page_phy, .page_reg, .page_val,
    .data_phy, .reg_lo, .reg_hi
  );

  mdio32_merge #(.REG_W(REG_W)) u_merge (
    .clk, .rst_n,
    .load      (accept),
    .clr_in    (cmd_clr),
    .set_in    (cmd_set),
    .cap_lo, .cap_hi,
    .rdata     (rsp_rdata),
    .raw_val, .merged_val
  );

  always_comb begin
    txn_write = 1'b0;
    txn_phy   = data_phy;
    txn_reg   = reg_lo;
    txn_wdata = '0;
    unique case (state)
      ST_PAGE: begin
        txn_write = 1'b1;
        txn_phy   = page_phy;
        txn_reg   = page_reg;
        txn_wdata = page_val;
      end
      ST_RD_HI: txn_reg = reg_hi;
      ST_WR_LO: begin
        txn_write = 1'b1;
        txn_wdata = merged_val[HALF_W-1:0];
      end
      ST_WR_HI: begin
        txn_write = 1'b1;
        txn_reg   = reg_hi;
        txn_wdata = merged_val[REG_W-1:HALF_W];
      end
      default: ;
    endcase
    done_data = done_err ? raw_val : merged_val;
  end

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R7
  AST_REQ_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && !rsp_valid) |=> ($stable(txn_phy) && $stable(txn_reg) &&
                                 $stable(txn_wdata) && $stable(txn_write))); // R6
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !txn_req); // R10

endmodule

// File: tb/sim_mdio32_rmw_seq.sv
module sim_mdio32_rmw_seq;

  typedef struct packed {
    logic        w;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] d;
  } txn_t;

  typedef struct packed {
    logic        err;
    logic [31:0] data;
  } res_t;

  logic clk, rst_n;
  logic cmd_valid, cmd_ready;
  logic [31:0] cmd_addr, cmd_clr, cmd_set;
  logic txn_req, txn_write;
  logic [4:0] txn_phy, txn_reg;
  logic [15:0] txn_wdata;
  logic rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic done, done_err;
  logic [31:0] done_data;

  int n_chk = 0;
  int n_fail = 0;

  txn_t exp_q[$];
  res_t res_q[$];

  logic [15:0] slv_lo, slv_hi;
  int slv_err_k, slv_lat, slv_idx;

  mdio32_rmw_seq u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bus model and request monitor
  initial begin
    rsp_valid = 1'b0; rsp_err = 1'b0; rsp_rdata = '0;
    forever begin
      @(negedge clk);
      if (txn_req) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 stray transaction", {txn_write, txn_phy, txn_reg}, 0);
        end else begin
          txn_t e, a;
          e = exp_q.pop_front();
          a = '{w: txn_write, phy: txn_phy, rg: txn_reg, d: (txn_write ? txn_wdata : 16'h0)};
          chk(a == e, (slv_idx == 0) ? "R2 page write" : (slv_idx < 3) ? "R3 read" : "R4 R5 write",
              64'(a), 64'(e));
        end
        for (int i = 0; i < slv_lat; i++) begin
          @(negedge clk);
          chk(txn_req == 1'b1, "R6 request held", txn_req, 1);
        end
        rsp_valid = 1'b1;
        rsp_err   = (slv_idx == slv_err_k);
        rsp_rdata = (slv_idx == 1) ? slv_lo : (slv_idx == 2) ? slv_hi : 16'hDEAD;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = 1'b0;
        chk(txn_req == 1'b0, "R6 gap after response", txn_req, 0);
        slv_idx++;
      end
    end
  end

  // result monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (res_q.size() == 0) begin
          chk(1'b0, "R9 unexpected done", done_data, 0);
        end else begin
          res_t e;
          e = res_q.pop_front();
          chk(done_err == e.err, e.err ? "R8 error flag" : "R9 error flag", done_err, e.err);
          chk(done_data == e.data, e.err ? "R8 partial data" : "R9 R5 merged data", done_data, e.data);
        end
        @(negedge clk);
        chk(done == 1'b0 && cmd_ready == 1'b1, "R9 pulse and ready", {done, cmd_ready}, 2'b01);
      end
    end
  end

  task automatic run_cmd(input logic [31:0] a, input logic [31:0] c, input logic [31:0] s,
                         input logic [15:0] lo, input logic [15:0] hi,
                         input int err_k, input int lat, input bit poke);
    txn_t seq[5];
    logic [31:0] merged, partial;
    int n;
    logic [4:0] dphy, rlo, rhi;
    dphy = 5'h10 | {2'b00, a[7:5]};
    rlo  = a[4:0];
    rhi  = a[4:0] | 5'h02;
    merged = ({hi, lo} & ~c) | s;
    seq[0] = '{w: 1'b1, phy: 5'h18 | 5'(a[31:24] >> 5), rg: a[28:24], d: a[23:8]};
    seq[1] = '{w: 1'b0, phy: dphy, rg: rlo, d: 16'h0};
    seq[2] = '{w: 1'b0, phy: dphy, rg: rhi, d: 16'h0};
    seq[3] = '{w: 1'b1, phy: dphy, rg: rlo, d: merged[15:0]};
    seq[4] = '{w: 1'b1, phy: dphy, rg: rhi, d: merged[31:16]};
    n = (err_k < 5) ? err_k + 1 : 5;
    for (int i = 0; i < n; i++) exp_q.push_back(seq[i]);
    partial = (err_k <= 1) ? 32'h0 : (err_k == 2) ? {16'h0, lo} : {hi, lo};
    res_q.push_back('{err: (err_k < 5), data: (err_k < 5) ? partial : merged});
    slv_lo = lo; slv_hi = hi; slv_err_k = err_k; slv_lat = lat; slv_idx = 0;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R9 ready before command", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_addr = a; cmd_clr = c; cmd_set = s;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (poke) begin
      chk(cmd_ready == 1'b0, "R7 busy", cmd_ready, 0);
      cmd_valid = 1'b1; cmd_addr = ~a; cmd_clr = 32'h0; cmd_set = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
    end
    wait (res_q.size() == 0);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10 transaction count", exp_q.size(), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cmd_valid = 1'b0; cmd_addr = '0; cmd_clr = '0; cmd_set = '0;
    slv_lo = '0; slv_hi = '0; slv_err_k = 5; slv_lat = 0; slv_idx = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1 && txn_req == 1'b0 && done == 1'b0, "R1 reset state",
        {cmd_ready, txn_req, done}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1 && txn_req == 1'b0, "R1 after release", {cmd_ready, txn_req}, 2'b10);

    run_cmd(32'hA75A_3CE8, 32'h0000_FFFF, 32'h1234_0000, 16'hBEEF, 16'hCAFE, 5, 0, 1'b0);
    run_cmd(32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 16'h1357, 16'h2468, 5, 2, 1'b1);
    run_cmd(32'hFFFF_FFFC, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 16'hFFFF, 16'hFFFF, 5, 3, 1'b0);
    run_cmd(32'h3C81_0044, 32'hF0F0_0F0F, 32'h0101_1010, 16'h55AA, 16'hAA55, 5, 1, 1'b1);
    for (int k = 0; k < 5; k++)
      run_cmd(32'h62C3_D5B0, 32'h00FF_00FF, 32'h8000_0001, 16'h4321, 16'h8765, k, k % 3, 1'b0);
    run_cmd(32'h1F00_AA14, 32'h0F0F_0F0F, 32'h0000_0000, 16'h9ABC, 16'hDEF0, 5, 0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule